// File: doc/BRIEF.md
# Dual-Byte 8b/10b Transmit Encoder

This block turns a 16-bit parallel transmit word into a 20-bit line word by encoding each byte with the standard 8b/10b transmission code. The result is DC balanced, has a bounded run length and carries enough transitions for clock recovery. Each byte has its own control flag. When the flag is clear the byte is encoded as a data character. When it is set the byte is encoded as a special (K) character. The low byte is encoded first. The high byte is then encoded with the running disparity the low byte leaves behind. The disparity at the end of the word carries over to the next clock cycle.

A serializer downstream shifts the 20-bit word out least significant bit first. The low character therefore goes on the line before the high character. A byte flagged as control that is not one of the twelve legal special characters is replaced by the comma K28.5, and an error flag is raised for that word.

Top module: `dual_8b10b_tx`

## Requirements
- R1: Bits 7:0 of `data_in` are encoded into `code_out[9:0]` and bits 15:8 into `code_out[19:10]`. Within each character, bit 0 holds code bit a, then b, c, d, e and i in bits 1 to 5, then f, g, h and j in bits 6 to 9.
- R2: A byte whose control flag is 0 is encoded as the data character of the standard 8b/10b code for the current running disparity. This includes the alternate x.A7 form where the code demands it.
- R3: A byte whose control flag is 1 and whose value is one of 0x1C, 0x3C, 0x5C, 0x7C, 0x9C, 0xBC, 0xDC, 0xFC (K28.0 to K28.7), 0xF7 (K23.7), 0xFB (K27.7), 0xFD (K29.7) or 0xFE (K30.7) is encoded as that special character.
- R4: The two control flags act independently. All four combinations give the per-byte encoding of R2 and R3.
- R5: Running disparity is negative (state 0) after reset. Every character holds 4, 5 or 6 ones. A character with 6 ones occurs only at negative disparity, and one with 4 ones only at positive disparity.
- R6: The high character uses the disparity left by the low character. The disparity after the high character is used by the next word's low character.
- R7: In the serial stream (code_out bit 0 first, word after word), no more than five equal bits occur in a row.
- R8: A byte with its control flag set that is not in the list of R3 is sent as K28.5 at the current disparity. `k_err` is 1 for exactly that output word. `k_err` is 0 for any word without such a byte.
- R9: `code_out` and `k_err` are registered. They change only at the clock edge after the input is applied, and are 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| data_in | input | 16 | Transmit word, low byte in 7:0 |
| k_lo | input | 1 | Low byte is a special character |
| k_hi | input | 1 | High byte is a special character |
| code_out | output | 20 | Encoded word, low character in 9:0 |
| k_err | output | 1 | Illegal special character seen in this word |

## Verification
The assertions assume that `data_in`, `k_lo` and `k_hi` hold known 0/1 values on every clock edge outside reset. They also assume that reset is held low over at least one rising edge before the first word, so the stored disparity starts from a defined state. The bench drives every input only on falling edges, starts with all inputs at zero under a multi-cycle reset, and never leaves an input unknown. The per-character weight and sign properties therefore meet only fully defined codes.

// File: rtl/tx8b10b_pkg.sv
package tx8b10b_pkg;

  localparam int BYTE_W  = 8;
  localparam int CHAR_W  = 10;
  localparam int LANES   = 2;
  localparam int IN_W    = LANES * BYTE_W;
  localparam int OUT_W   = LANES * CHAR_W;
  localparam logic [7:0] COMMA_BYTE = 8'hBC;

  // 5b/6b sub-block at negative disparity, code bit a at [5] ... i at [0]
  function automatic logic [5:0] six_neg(input logic [4:0] x);
    case (x)
      5'd0:  return 6'b100111;
      5'd1:  return 6'b011101;
      5'd2:  return 6'b101101;
      5'd3:  return 6'b110001;
      5'd4:  return 6'b110101;
      5'd5:  return 6'b101001;
      5'd6:  return 6'b011001;
      5'd7:  return 6'b111000;
      5'd8:  return 6'b111001;
      5'd9:  return 6'b100101;
      5'd10: return 6'b010101;
      5'd11: return 6'b110100;
      5'd12: return 6'b001101;
      5'd13: return 6'b101100;
      5'd14: return 6'b011100;
      5'd15: return 6'b010111;
      5'd16: return 6'b011011;
      5'd17: return 6'b100011;
      5'd18: return 6'b010011;
      5'd19: return 6'b110010;
      5'd20: return 6'b001011;
      5'd21: return 6'b101010;
      5'd22: return 6'b011010;
      5'd23: return 6'b111010;
      5'd24: return 6'b110011;
      5'd25: return 6'b100110;
      5'd26: return 6'b010110;
      5'd27: return 6'b110110;
      5'd28: return 6'b001110;
      5'd29: return 6'b101110;
      5'd30: return 6'b011110;
      default: return 6'b101011;
    endcase
  endfunction

  // 3b/4b sub-block for data at negative disparity, f at [3] ... j at [0]
  function automatic logic [3:0] four_neg_data(input logic [2:0] y, input logic alt7);
    case (y)
      3'd0: return 4'b1011;
      3'd1: return 4'b1001;
      3'd2: return 4'b0101;
      3'd3: return 4'b1100;
      3'd4: return 4'b1101;
      3'd5: return 4'b1010;
      3'd6: return 4'b0110;
      default: return alt7 ? 4'b0111 : 4'b1110;
    endcase
  endfunction

  // 3b/4b sub-block for special characters at negative disparity
  function automatic logic [3:0] four_neg_ctrl(input logic [2:0] y);
    case (y)
      3'd0: return 4'b1011;
      3'd1: return 4'b0110;
      3'd2: return 4'b1010;
      3'd3: return 4'b1100;
      3'd4: return 4'b1101;
      3'd5: return 4'b0101;
      3'd6: return 4'b1001;
      default: return 4'b0111;
    endcase
  endfunction

  function automatic logic ctrl_is_legal(input logic [7:0] b);
    logic [4:0] x;
    x = b[4:0];
    return (x == 5'd28) ||
           ((b[7:5] == 3'd7) && (x == 5'd23 || x == 5'd27 || x == 5'd29 || x == 5'd30));
  endfunction

  // alternate x.7 form avoids a run of five across the sub-block boundary
  function automatic logic need_alt7(input logic [4:0] x, input logic rd_pos);
    if (rd_pos) return (x == 5'd11) || (x == 5'd13) || (x == 5'd14);
    else        return (x == 5'd17) || (x == 5'd18) || (x == 5'd20);
  endfunction

  // reorder {a..i,f..j} so that code bit a lands in bit 0
  function automatic logic [CHAR_W-1:0] line_order(input logic [CHAR_W-1:0] v);
    logic [CHAR_W-1:0] r;
    for (int i = 0; i < CHAR_W; i++) r[i] = v[CHAR_W-1-i];
    return r;
  endfunction

endpackage

// File: rtl/byte_enc_8b10b.sv
module byte_enc_8b10b
  import tx8b10b_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              k_in,
  input  logic              rd_in,
  output logic [CHAR_W-1:0] char_out,
  output logic              rd_out,
  output logic              bad_k
);

  logic [BYTE_W-1:0] eff_byte;
  logic [4:0]        x5;
  logic [2:0]        y3;
  logic              is_k28;
  logic [5:0]        six_base;
  logic [5:0]        six_sel;
  logic              six_bal;
  logic              rd_mid;
  logic              alt7;
  logic [3:0]        four_base;
  logic [3:0]        four_sel;
  logic              four_bal;
  logic              four_inv;

  always_comb begin
    bad_k    = k_in && !ctrl_is_legal(byte_in);
    eff_byte = bad_k ? COMMA_BYTE : byte_in;
    x5       = eff_byte[4:0];
    y3       = eff_byte[7:5];
    is_k28   = k_in && (x5 == 5'd28);

    six_base = is_k28 ? 6'b001111 : six_neg(x5);
    six_bal  = ($countones(six_base) == 3);
    six_sel  = six_base;
    if (rd_in) begin
      if (!six_bal)                six_sel = ~six_base;
      else if (x5 == 5'd7 && !k_in) six_sel = 6'b000111;
    end
    rd_mid = six_bal ? rd_in : ~rd_in;

    alt7      = (y3 == 3'd7) && (k_in || need_alt7(x5, rd_mid));
    four_base = k_in ? four_neg_ctrl(y3) : four_neg_data(y3, alt7);
    four_bal  = ($countones(four_base) == 2);
    four_inv  = k_in || !four_bal || (y3 == 3'd3);
    four_sel  = (rd_mid && four_inv) ? ~four_base : four_base;
    rd_out    = four_bal ? rd_mid : ~rd_mid;

    char_out  = line_order({six_sel, four_sel});
  end

endmodule

// File: rtl/tx_out_stage.sv
module tx_out_stage #(
  parameter int WIDTH = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] code_d,
  input  logic             err_d,
  input  logic             rd_d,
  output logic [WIDTH-1:0] code_q,
  output logic             err_q,
  output logic             rd_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= '0;
      err_q  <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      code_q <= code_d;
      err_q  <= err_d;
      rd_q   <= rd_d;
    end
  end

  // R5: disparity state is negative on the first edge after reset
  assert_rd_starts_neg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (rd_q == 1'b0));

endmodule

// File: rtl/dual_8b10b_tx.sv
module dual_8b10b_tx
  import tx8b10b_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [15:0]     data_in,
  input  logic            k_lo,
  input  logic            k_hi,
  output logic [19:0]     code_out,
  output logic            k_err
);

  localparam logic [CHAR_W-1:0] COMMA_NEG = 10'b0101111100;
  localparam logic [CHAR_W-1:0] COMMA_POS = 10'b1010000011;

  logic [LANES-1:0]             k_vec;
  logic [LANES:0]               rd_chain;
  logic [LANES-1:0][CHAR_W-1:0] lane_char;
  logic [LANES-1:0]             lane_bad;
  logic                         word_bad;
  logic                         rd_state;

  assign k_vec       = {k_hi, k_lo};
  assign rd_chain[0] = rd_state;
  assign word_bad    = |lane_bad;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    byte_enc_8b10b u_enc (
      .byte_in  (data_in[g*BYTE_W +: BYTE_W]),
      .k_in     (k_vec[g]),
      .rd_in    (rd_chain[g]),
      .char_out (lane_char[g]),
      .rd_out   (rd_chain[g+1]),
      .bad_k    (lane_bad[g])
    );

    // R5: character weight stays within one of balance
    assert_char_weight_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(lane_char[g]) >= 4) && ($countones(lane_char[g]) <= 6));

    // R5: heavy characters only at negative disparity, light ones only at positive
    assert_char_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_chain[g] ? ($countones(lane_char[g]) <= 5) : ($countones(lane_char[g]) >= 5));

    // R6: disparity handed on flips exactly when the character is unbalanced
    assert_rd_handoff_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(lane_char[g]) == 5) == (rd_chain[g+1] == rd_chain[g]));

    // R8: an illegal special byte leaves the lane as the comma
    assert_bad_is_comma_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lane_bad[g] |-> (lane_char[g] == (rd_chain[g] ? COMMA_POS : COMMA_NEG)));
  end

  tx_out_stage #(.WIDTH(OUT_W)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .code_d (lane_char),
    .err_d  (word_bad),
    .rd_d   (rd_chain[LANES]),
    .code_q (code_out),
    .err_q  (k_err),
    .rd_q   (rd_state)
  );

  // R9: the error flag follows the word it belongs to by one edge
  assert_err_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (k_err == $past(word_bad)));

endmodule

// File: tb/test_dual_8b10b_tx.sv
`timescale 1ns/1ps
module test_dual_8b10b_tx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] data_in = '0;
  logic        k_lo = 1'b0;
  logic        k_hi = 1'b0;
  logic [19:0] code_out;
  logic        k_err;

  int checks = 0;
  int failures = 0;

  logic        m_rd;
  logic [19:0] exp_code;
  logic        exp_err;
  string       exp_req;
  bit          pend;
  logic        run_rd;
  logic        last_bit;
  int          run_len;
  bit          have_bit;

  always #5 clk = ~clk;

  dual_8b10b_tx i_dual_8b10b_tx (
    .clk(clk), .rst_n(rst_n), .data_in(data_in),
    .k_lo(k_lo), .k_hi(k_hi), .code_out(code_out), .k_err(k_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] tb_six(input logic [4:0] x);
    logic [5:0] t [32];
    t = '{6'b100111, 6'b011101, 6'b101101, 6'b110001, 6'b110101, 6'b101001, 6'b011001, 6'b111000,
          6'b111001, 6'b100101, 6'b010101, 6'b110100, 6'b001101, 6'b101100, 6'b011100, 6'b010111,
          6'b011011, 6'b100011, 6'b010011, 6'b110010, 6'b001011, 6'b101010, 6'b011010, 6'b111010,
          6'b110011, 6'b100110, 6'b010110, 6'b110110, 6'b001110, 6'b101110, 6'b011110, 6'b101011};
    return t[x];
  endfunction

  // returns {negative-disparity form, positive-disparity form}
  function automatic logic [7:0] tb_four(input logic [2:0] y, input logic k, input logic alt);
    if (k) begin
      case (y)
        3'd0: return 8'b1011_0100;  3'd1: return 8'b0110_1001;
        3'd2: return 8'b1010_0101;  3'd3: return 8'b1100_0011;
        3'd4: return 8'b1101_0010;  3'd5: return 8'b0101_1010;
        3'd6: return 8'b1001_0110;  default: return 8'b0111_1000;
      endcase
    end
    case (y)
      3'd0: return 8'b1011_0100;  3'd1: return 8'b1001_1001;
      3'd2: return 8'b0101_0101;  3'd3: return 8'b1100_0011;
      3'd4: return 8'b1101_0010;  3'd5: return 8'b1010_1010;
      3'd6: return 8'b0110_0110;
      default: return alt ? 8'b0111_1000 : 8'b1110_0001;
    endcase
  endfunction

  function automatic bit tb_legal(input logic [7:0] b);
    return (b[4:0] == 5'd28) ||
           (b[7:5] == 3'd7 && (b[4:0] == 5'd23 || b[4:0] == 5'd27 || b[4:0] == 5'd29 || b[4:0] == 5'd30));
  endfunction

  // returns {disparity after, character with bit a in bit 0}
  function automatic logic [10:0] tb_encode(input logic [7:0] b_in, input logic k, input logic rd_in);
    logic [7:0] b;
    logic [5:0] s;
    logic [3:0] f;
    logic [7:0] pair;
    logic       rd;
    logic       alt;
    logic [9:0] c;
    b  = (k && !tb_legal(b_in)) ? 8'hBC : b_in;
    rd = rd_in;
    s  = (k && b[4:0] == 5'd28) ? 6'b001111 : tb_six(b[4:0]);
    if (rd) begin
      if ($countones(s) != 3) s = ~s;
      else if (b[4:0] == 5'd7 && !k) s = 6'b000111;
    end
    if ($countones(s) != 3) rd = ~rd;
    alt = rd ? (b[4:0] == 5'd11 || b[4:0] == 5'd13 || b[4:0] == 5'd14)
             : (b[4:0] == 5'd17 || b[4:0] == 5'd18 || b[4:0] == 5'd20);
    pair = tb_four(b[7:5], k, alt);
    f = rd ? pair[3:0] : pair[7:4];
    if ($countones(f) != 2) rd = ~rd;
    for (int j = 0; j < 6; j++) c[j] = s[5-j];
    for (int j = 0; j < 4; j++) c[6+j] = f[3-j];
    return {rd, c};
  endfunction

  task automatic check_out();
    logic [9:0] ch;
    int ones;
    chk(code_out[9:0] == exp_code[9:0], {exp_req, " R1 low character"}, code_out[9:0], exp_code[9:0]);
    chk(code_out[19:10] == exp_code[19:10], {exp_req, " R6 high character"}, code_out[19:10], exp_code[19:10]);
    chk(k_err == exp_err, "R8 error flag", k_err, exp_err);
    for (int l = 0; l < 2; l++) begin
      ch = code_out[l*10 +: 10];
      ones = $countones(ch);
      chk((ones == 5) || (ones == 6 && !run_rd) || (ones == 4 && run_rd),
          "R5 character disparity", ones, run_rd ? 4 : 6);
      if (ones != 5) run_rd = ~run_rd;
    end
    for (int i = 0; i < 20; i++) begin
      if (have_bit && code_out[i] == last_bit) run_len++;
      else run_len = 1;
      last_bit = code_out[i];
      have_bit = 1;
      if (run_len > 5) break;
    end
    chk(run_len <= 5, "R7 run length", run_len, 5);
  endtask

  task automatic apply(input logic [7:0] lo, input logic [7:0] hi, input logic klo, input logic khi, input string req);
    logic [10:0] r0;
    logic [10:0] r1;
    logic [19:0] held;
    @(negedge clk);
    if (pend) check_out();
    held = code_out;
    data_in = {hi, lo};
    k_lo = klo;
    k_hi = khi;
    r0 = tb_encode(lo, klo, m_rd);
    r1 = tb_encode(hi, khi, r0[10]);
    exp_code = {r1[9:0], r0[9:0]};
    m_rd = r1[10];
    exp_err = (klo && !tb_legal(lo)) || (khi && !tb_legal(hi));
    exp_req = req;
    pend = 1;
    #1;
    chk(code_out == held, "R9 no change before edge", code_out, held);
  endtask

  logic [7:0] legal_k [12];

  initial begin
    legal_k = '{8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC, 8'hDC, 8'hFC, 8'hF7, 8'hFB, 8'hFD, 8'hFE};
    m_rd = 1'b0; run_rd = 1'b0; pend = 0; have_bit = 0; run_len = 0; last_bit = 1'b0;
    repeat (4) @(negedge clk);
    chk(code_out == 20'd0, "R9 reset code", code_out, 0);
    chk(k_err == 1'b0, "R9 reset error flag", k_err, 0);
    rst_n = 1'b1;

    // R2: every data value in both lanes, disparity carried across words (R6)
    for (int i = 0; i < 256; i++) apply(i[7:0], 8'(255 - i), 1'b0, 1'b0, "R2 data sweep");
    for (int i = 0; i < 256; i++) apply(i[7:0], 8'(i * 7 + 3), 1'b0, 1'b0, "R2 data mix");
    // R3 R4: all flag combinations with every legal special character
    for (int a = 0; a < 12; a++)
      for (int b = 0; b < 12; b++) apply(legal_k[a], legal_k[b], 1'b1, 1'b1, "R3 R4 both special");
    for (int a = 0; a < 12; a++)
      for (int d = 0; d < 256; d += 17) begin
        apply(legal_k[a], d[7:0], 1'b1, 1'b0, "R4 low special");
        apply(d[7:0], legal_k[a], 1'b0, 1'b1, "R4 high special");
      end
    // R8: illegal special bytes in each lane, then clean words
    apply(8'h00, 8'h12, 1'b1, 1'b0, "R8 bad low");
    apply(8'h12, 8'h00, 1'b0, 1'b0, "R8 clean");
    apply(8'h34, 8'hA5, 1'b0, 1'b1, "R8 bad high");
    apply(8'h3E, 8'hFF, 1'b1, 1'b1, "R8 bad both");
    apply(8'h37, 8'hBC, 1'b1, 1'b1, "R8 bad low good high");
    apply(8'hBC, 8'hBC, 1'b0, 1'b0, "R8 flags clear");
    @(negedge clk);
    check_out();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule